// File: doc/BRIEF.md
# Register Move Datapath

This block carries out the register-to-register move of a small programmable I/O sequencer. In one cycle it picks a 32-bit operand with a 3-bit source code, optionally complements it or mirrors its bit order, and hands the result to one destination. A destination can be a scratch register, a shift register or the pin latch. It can also be the program counter, which makes the move a jump. The last option is the execute path, which feeds the value back into the sequencer as the instruction of the following cycle.

The surrounding sequencer decodes the instruction and issues it with `mv_valid`. It supplies the current register and pin values and a status condition that it has already selected. It consumes the write enables, the shared write data, the jump target, the delay count and the execute request. Instruction fetch, FIFOs and pin drivers live outside the block.

Top module: `mov_exec_unit`

## Requirements
- R1: With operation code 00, the write data equals the operand chosen by the source code: 000 input pins, 001 X, 010 Y, 011 constant zero, 110 input shift register, 111 output shift register.
- R2: Source code 101 yields all 32 bits set while `status_cond` is 1 and all 32 bits clear while it is 0.
- R3: Operation code 01 drives the bitwise complement of the chosen operand onto the write data.
- R4: Operation code 10 puts operand bit 31-n onto write data bit n for every n. Operation code 11 behaves like 00.
- R5: While `mv_valid` is high, destination code 000 raises `pins_we`, 001 `x_we`, 010 `y_we`, 100 `pc_load`, 101 `isr_we` and 110 `osr_we`, in the same cycle. Codes 011 and 111 raise none of these. No enable is raised while `mv_valid` is low.
- R6: A move to destination 100 loads the program counter with the low 5 bits of the result in the same cycle.
- R7: A move to destination 011 raises `exec_req` for exactly the following cycle, with `exec_instr` holding the low 16 bits of that move's result.
- R8: `delay_out` repeats `delay_in` for a valid move to any destination except 011. It is zero for a move to 011 and zero while `mv_valid` is low.
- R9: Source code 100 gives a result of zero. From the next cycle `illegal_src` is set, and it stays set until reset.
- R10: After reset, `exec_req` and `illegal_src` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mv_valid | input | 1 | A move instruction is issued this cycle |
| src_sel | input | 3 | Source code |
| dst_sel | input | 3 | Destination code |
| op_sel | input | 2 | Operation code |
| delay_in | input | 5 | Delay count carried by the instruction |
| status_cond | input | 1 | Selected status condition |
| pins_in | input | 32 | Input pin values, already mapped |
| x_in | input | 32 | Scratch register X |
| y_in | input | 32 | Scratch register Y |
| isr_in | input | 32 | Input shift register |
| osr_in | input | 32 | Output shift register |
| wr_data | output | 32 | Move result |
| pins_we | output | 1 | Write pin latch |
| x_we | output | 1 | Write X |
| y_we | output | 1 | Write Y |
| isr_we | output | 1 | Write input shift register |
| osr_we | output | 1 | Write output shift register |
| pc_load | output | 1 | Load program counter |
| pc_value | output | 5 | Jump target |
| delay_out | output | 5 | Delay count to apply after the move |
| exec_req | output | 1 | Run `exec_instr` this cycle |
| exec_instr | output | 16 | Instruction to run |
| illegal_src | output | 1 | Sticky reserved-source flag |

## Verification
The checker watches every cycle for the properties that do not depend on operand values. At most one write or load strobe is active at a time. The jump target always matches the low bits of the result. An execute move never passes its delay on. Each execute request traces back to an execute move one cycle earlier and carries that move's result. The illegal flag never drops once it is set. Whether each source code, complement and bit mirror yields the right value, and whether the status operand follows its condition, can only be shown by the bench's directed scenarios, which compare the result against known operands.

// File: rtl/mov_exec_unit.sv
module mov_exec_unit #(
  parameter int DATA_W  = 32,
  parameter int PC_W    = 5,
  parameter int INSTR_W = 16,
  parameter int DLY_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mv_valid,
  input  logic [2:0]         src_sel,
  input  logic [2:0]         dst_sel,
  input  logic [1:0]         op_sel,
  input  logic [DLY_W-1:0]   delay_in,
  input  logic               status_cond,
  input  logic [DATA_W-1:0]  pins_in,
  input  logic [DATA_W-1:0]  x_in,
  input  logic [DATA_W-1:0]  y_in,
  input  logic [DATA_W-1:0]  isr_in,
  input  logic [DATA_W-1:0]  osr_in,
  output logic [DATA_W-1:0]  wr_data,
  output logic               pins_we,
  output logic               x_we,
  output logic               y_we,
  output logic               isr_we,
  output logic               osr_we,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_value,
  output logic [DLY_W-1:0]   delay_out,
  output logic               exec_req,
  output logic [INSTR_W-1:0] exec_instr,
  output logic               illegal_src
);

  logic [DATA_W-1:0] operand, mirrored;
  logic              to_exec;

  always_comb begin
    case (src_sel)
      3'b000:  operand = pins_in;
      3'b001:  operand = x_in;
      3'b010:  operand = y_in;
      3'b101:  operand = {DATA_W{status_cond}};
      3'b110:  operand = isr_in;
      3'b111:  operand = osr_in;
      default: operand = '0;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign mirrored[i] = operand[DATA_W-1-i];
  end

  always_comb begin
    case (op_sel)
      2'b01:   wr_data = ~operand;
      2'b10:   wr_data = mirrored;
      default: wr_data = operand;
    endcase
  end

  assign pins_we   = mv_valid && dst_sel == 3'b000;
  assign x_we      = mv_valid && dst_sel == 3'b001;
  assign y_we      = mv_valid && dst_sel == 3'b010;
  assign to_exec   = mv_valid && dst_sel == 3'b011;
  assign pc_load   = mv_valid && dst_sel == 3'b100;
  assign isr_we    = mv_valid && dst_sel == 3'b101;
  assign osr_we    = mv_valid && dst_sel == 3'b110;
  assign pc_value  = wr_data[PC_W-1:0];
  assign delay_out = (mv_valid && !to_exec) ? delay_in : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_req    <= 1'b0;
      exec_instr  <= '0;
      illegal_src <= 1'b0;
    end else begin
      exec_req <= to_exec;
      if (to_exec) exec_instr <= wr_data[INSTR_W-1:0];
      if (mv_valid && src_sel == 3'b100) illegal_src <= 1'b1;
    end
  end

endmodule

// File: rtl/mov_exec_unit_chk.sv
module mov_exec_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mv_valid,
  input logic [2:0]  dst_sel,
  input logic [31:0] wr_data,
  input logic        pins_we,
  input logic        x_we,
  input logic        y_we,
  input logic        isr_we,
  input logic        osr_we,
  input logic        pc_load,
  input logic [4:0]  pc_value,
  input logic [4:0]  delay_out,
  input logic        exec_req,
  input logic [15:0] exec_instr,
  input logic        illegal_src
);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pins_we, x_we, y_we, isr_we, osr_we, pc_load}));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_valid |-> !(pins_we || x_we || y_we || isr_we || osr_we || pc_load));

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> pc_value == wr_data[4:0]);

  // R7
  exec_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && dst_sel == 3'b011) |=> (exec_req && exec_instr == $past(wr_data[15:0])));

  // R7
  exec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |-> $past(mv_valid && dst_sel == 3'b011));

  // R8
  exec_nodelay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && dst_sel == 3'b011) |-> delay_out == 5'd0);

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_src |=> illegal_src);

endmodule

bind mov_exec_unit mov_exec_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .dst_sel(dst_sel),
  .wr_data(wr_data), .pins_we(pins_we), .x_we(x_we), .y_we(y_we),
  .isr_we(isr_we), .osr_we(osr_we), .pc_load(pc_load), .pc_value(pc_value),
  .delay_out(delay_out), .exec_req(exec_req), .exec_instr(exec_instr),
  .illegal_src(illegal_src)
);

// File: tb/mov_exec_unit_tb.sv
module mov_exec_unit_tb;
  logic clk = 0, rst_n = 0, mv_valid = 0, status_cond = 0;
  logic [2:0] src_sel = 0, dst_sel = 3'b111;
  logic [1:0] op_sel = 0;
  logic [4:0] delay_in = 0;
  logic [31:0] pins_in = 32'hDEADBEEF, x_in = 32'h12345678, y_in = 32'hA5A50F0F;
  logic [31:0] isr_in = 32'h000000FF, osr_in = 32'h80000003;
  logic [31:0] wr_data;
  logic pins_we, x_we, y_we, isr_we, osr_we, pc_load, exec_req, illegal_src;
  logic [4:0] pc_value, delay_out;
  logic [15:0] exec_instr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mov_exec_unit u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] flip(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic issue(logic [2:0] s, logic [2:0] d, logic [1:0] o, logic [4:0] dl);
    @(negedge clk);
    mv_valid = 1; src_sel = s; dst_sel = d; op_sel = o; delay_in = dl;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    mv_valid = 0; dst_sel = 3'b111; src_sel = 0;
    #1;
  endtask

  task automatic t_reset();
    check("R10 exec_req", {31'b0, exec_req}, 0);
    check("R10 illegal", {31'b0, illegal_src}, 0);
  endtask

  task automatic t_sources();
    issue(3'b000, 3'b001, 2'b00, 0); check("R1 pins", wr_data, pins_in);
    check("R5 x_we", {31'b0, x_we}, 1);
    issue(3'b001, 3'b010, 2'b00, 0); check("R1 x", wr_data, x_in);
    check("R5 y_we", {31'b0, y_we}, 1);
    issue(3'b010, 3'b000, 2'b00, 0); check("R1 y", wr_data, y_in);
    check("R5 pins_we", {31'b0, pins_we}, 1);
    issue(3'b011, 3'b101, 2'b00, 0); check("R1 null", wr_data, 0);
    check("R5 isr_we", {31'b0, isr_we}, 1);
    issue(3'b110, 3'b110, 2'b00, 0); check("R1 isr", wr_data, isr_in);
    check("R5 osr_we", {31'b0, osr_we}, 1);
    issue(3'b111, 3'b111, 2'b00, 0); check("R1 osr", wr_data, osr_in);
    check("R5 no strobe on 111", {26'b0, pins_we, x_we, y_we, isr_we, osr_we, pc_load}, 0);
    idle(); check("R5 idle strobes", {26'b0, pins_we, x_we, y_we, isr_we, osr_we, pc_load}, 0);
  endtask

  task automatic t_status();
    status_cond = 1; issue(3'b101, 3'b001, 2'b00, 0); check("R2 status set", wr_data, 32'hFFFFFFFF);
    status_cond = 0; #1; check("R2 status clear", wr_data, 0);
    idle();
  endtask

  task automatic t_ops();
    issue(3'b001, 3'b001, 2'b01, 0); check("R3 invert", wr_data, ~x_in);
    issue(3'b001, 3'b001, 2'b10, 0); check("R4 reverse", wr_data, flip(x_in));
    issue(3'b111, 3'b001, 2'b10, 0); check("R4 reverse osr", wr_data, 32'hC0000001);
    issue(3'b010, 3'b001, 2'b11, 0); check("R4 op 11 as none", wr_data, y_in);
    idle();
  endtask

  task automatic t_jump();
    issue(3'b000, 3'b100, 2'b00, 5'd7);
    check("R6 pc_load", {31'b0, pc_load}, 1);
    check("R6 pc_value", {27'b0, pc_value}, {27'b0, pins_in[4:0]});
    check("R8 delay passed", {27'b0, delay_out}, 7);
    idle(); check("R8 delay idle", {27'b0, delay_out}, 0);
  endtask

  task automatic t_exec();
    issue(3'b001, 3'b011, 2'b01, 5'd9);
    check("R8 exec delay dropped", {27'b0, delay_out}, 0);
    check("R7 no req same cycle", {31'b0, exec_req}, 0);
    check("R7 no strobe", {26'b0, pins_we, x_we, y_we, isr_we, osr_we, pc_load}, 0);
    idle();
    check("R7 exec_req", {31'b0, exec_req}, 1);
    check("R7 exec_instr", {16'b0, exec_instr}, {16'b0, ~x_in[15:0]});
    idle();
    check("R7 single cycle", {31'b0, exec_req}, 0);
  endtask

  task automatic t_illegal();
    issue(3'b100, 3'b001, 2'b00, 0);
    check("R9 zero", wr_data, 0);
    check("R9 not yet", {31'b0, illegal_src}, 0);
    idle(); check("R9 set", {31'b0, illegal_src}, 1);
    repeat (3) idle();
    check("R9 sticky", {31'b0, illegal_src}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_n = 1;
    t_sources();
    t_status();
    t_ops();
    t_jump();
    t_exec();
    t_illegal();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule